// File: doc/BRIEF.md
# Write-Through Store Queue

This block sits between a processor whose cache writes through on every store and a slow main memory. Each store is written into the cache and, in the same cycle, queued here. The processor then moves on without waiting for the memory write. Each queue slot keeps a valid flag, a target address and a data word.

A drain controller takes the oldest slot, holds a main-memory write for a fixed number of cycles (five by default), and then frees the slot. Slots leave in arrival order, so memory sees stores in program order.

The block raises two hold signals:
- One holds a store that arrives while every slot is occupied, unless a slot frees in that same cycle.
- The other holds a read miss until every queued store has reached memory, so the read cannot overtake older writes.

Top module: `store_drain_queue`

## Requirements
- R1: After reset the queue is empty (`bufEmpty`=1, `bufFull`=0), no memory write is active, and neither `stStall` nor `rdStall` is asserted.
- R2: Every accepted store (`stValid`=1 and `stStall`=0 at a clock edge) reaches memory exactly once, with the address and data it was accepted with.
- R3: Stores reach memory in the order they were accepted. When two stores target one address, the later data is what memory holds at the end.
- R4: Each memory write keeps `memWrEn` high for exactly MEM_LAT consecutive cycles (default 5), with `memWrAddr` and `memWrData` stable throughout. `memCommit` pulses on the last of those cycles.
- R5: A store offered while the queue is full, in a cycle without `memCommit`, sees `stStall`=1 and is not taken.
- R6: A store offered while the queue is full, in a cycle with `memCommit`, is accepted with `stStall`=0, and the queue is still full afterwards.
- R7: `rdStall` is 1 exactly when `rdMissReq` is 1 and the queue holds at least one store. When a read miss is released, every earlier store has completed and no memory write is active.
- R8: `bufFull` is 1 when DEPTH stores are held (default 4), and `bufEmpty` is 1 when none are held. The two are never 1 together.
- R9: When stores remain after a commit, the next memory write begins in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stValid | input | 1 | Processor offers a store this cycle |
| stAddr | input | ADDR_W | Store address |
| stData | input | DATA_W | Store data |
| stStall | output | 1 | Store not taken this cycle; hold it |
| rdMissReq | input | 1 | Read miss wants main memory |
| rdStall | output | 1 | Read miss must wait for the queue to drain |
| memWrEn | output | 1 | Memory write in progress |
| memWrAddr | output | ADDR_W | Address of the write in progress |
| memWrData | output | DATA_W | Data of the write in progress |
| memCommit | output | 1 | Final cycle of the write; slot is freed at this edge |
| bufEmpty | output | 1 | No stores held |
| bufFull | output | 1 | All DEPTH slots held |

## Verification
The bound checker covers the following on every cycle:
- the hold rules for a full queue, with and without a commit in that cycle;
- the length of each memory write, and that its address and data stay stable;
- that no memory write is active once a read miss is released;
- that the two flags never conflict;
- that the valid bits agree with the occupancy count;
- that draining continues with no gap.

Only the bench's scenarios can show the following:
- that memory receives every store once, in program order, with the right values;
- that an overwritten address ends with its latest data;
- that a released read miss finds all earlier stores already written.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  typedef enum logic [0:0] {
    DRAIN_IDLE = 1'b0,
    DRAIN_BUSY = 1'b1
  } drainState_t;

  typedef struct packed {
    logic push;
    logic pop;
  } sbufStrobes_t;

endpackage

// File: rtl/sbuf_datapath.sv
module sbuf_datapath
  import sbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbufStrobes_t      strobes,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  occupancy,
  output logic [DEPTH-1:0]  validVec,
  output logic              bufEmpty,
  output logic              bufFull
);

  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];

  function automatic logic [PTR_W-1:0] advancePtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hitWr;
    logic hitRd;
    assign hitWr = strobes.push && (wrPtr == PTR_W'(i));
    assign hitRd = strobes.pop  && (rdPtr == PTR_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validVec[i] <= 1'b0;
      end else if (hitWr) begin
        validVec[i] <= 1'b1;
      end else if (hitRd) begin
        validVec[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (hitWr) begin
        addrMem[i] <= stAddr;
        dataMem[i] <= stData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occupancy <= '0;
    end else begin
      if (strobes.push) wrPtr <= advancePtr(wrPtr);
      if (strobes.pop)  rdPtr <= advancePtr(rdPtr);
      case ({strobes.push, strobes.pop})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
    end
  end

  assign headAddr = addrMem[rdPtr];
  assign headData = dataMem[rdPtr];
  assign bufEmpty = (occupancy == '0);
  assign bufFull  = (occupancy == CNT_W'(DEPTH));

endmodule

// File: rtl/sbuf_control.sv
module sbuf_control
  import sbuf_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int MEM_LAT = 5,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LAT_W  = (MEM_LAT > 1) ? $clog2(MEM_LAT) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stValid,
  input  logic             rdMissReq,
  input  logic             bufEmpty,
  input  logic             bufFull,
  input  logic [CNT_W-1:0] occupancy,
  output sbufStrobes_t     strobes,
  output logic             stStall,
  output logic             rdStall,
  output logic             memWrEn,
  output logic             memCommit
);

  drainState_t state;
  logic [LAT_W-1:0] latCnt;
  logic moreAfterPop;

  assign memWrEn   = (state == DRAIN_BUSY);
  assign memCommit = memWrEn && (latCnt == LAT_W'(MEM_LAT - 1));

  assign stStall       = stValid && bufFull && !memCommit;
  assign strobes.push  = stValid && !stStall;
  assign strobes.pop   = memCommit;
  assign rdStall       = rdMissReq && !bufEmpty;
  assign moreAfterPop  = (occupancy > CNT_W'(1)) || strobes.push;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= DRAIN_IDLE;
      latCnt <= '0;
    end else begin
      case (state)
        DRAIN_IDLE: begin
          latCnt <= '0;
          if (!bufEmpty) state <= DRAIN_BUSY;
        end
        DRAIN_BUSY: begin
          if (memCommit) begin
            latCnt <= '0;
            state  <= moreAfterPop ? DRAIN_BUSY : DRAIN_IDLE;
          end else begin
            latCnt <= latCnt + 1'b1;
          end
        end
        default: state <= DRAIN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/store_drain_queue.sv
module store_drain_queue
  import sbuf_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 4,
  parameter int MEM_LAT = 5,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  output logic              stStall,
  input  logic              rdMissReq,
  output logic              rdStall,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memCommit,
  output logic              bufEmpty,
  output logic              bufFull
);

  sbufStrobes_t     strobes;
  logic [CNT_W-1:0] occupancy;
  logic [DEPTH-1:0] validVec;

  sbuf_control #(
    .DEPTH  (DEPTH),
    .MEM_LAT(MEM_LAT)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .stValid  (stValid),
    .rdMissReq(rdMissReq),
    .bufEmpty (bufEmpty),
    .bufFull  (bufFull),
    .occupancy(occupancy),
    .strobes  (strobes),
    .stStall  (stStall),
    .rdStall  (rdStall),
    .memWrEn  (memWrEn),
    .memCommit(memCommit)
  );

  sbuf_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .stAddr   (stAddr),
    .stData   (stData),
    .headAddr (memWrAddr),
    .headData (memWrData),
    .occupancy(occupancy),
    .validVec (validVec),
    .bufEmpty (bufEmpty),
    .bufFull  (bufFull)
  );

endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 4,
  parameter int MEM_LAT = 5,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              stValid,
  input logic              stStall,
  input logic              rdMissReq,
  input logic              rdStall,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic              memCommit,
  input logic              bufEmpty,
  input logic              bufFull,
  input logic [CNT_W-1:0]  occupancy,
  input logic [DEPTH-1:0]  validVec
);

  int runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          runCnt <= 0;
    else if (memCommit) runCnt <= 0;
    else if (memWrEn)   runCnt <= runCnt + 1;
  end

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && bufFull && !memCommit) |-> stStall); // R5

  AST_FULL_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && bufFull && memCommit) |=> bufFull); // R6

  AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !memCommit) |=> (memWrEn && $stable(memWrAddr) && $stable(memWrData))); // R4

  AST_WR_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    memCommit |-> (memWrEn && runCnt == MEM_LAT - 1)); // R4

  AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (rdMissReq && !rdStall) |-> !memWrEn); // R7

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(bufEmpty && bufFull)); // R8

  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $countones(validVec) == int'(occupancy)); // R2

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rstN)
    memCommit |=> (memWrEn || bufEmpty)); // R9

endmodule

bind store_drain_queue sbuf_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .MEM_LAT(MEM_LAT)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .stValid  (stValid),
  .stStall  (stStall),
  .rdMissReq(rdMissReq),
  .rdStall  (rdStall),
  .memWrEn  (memWrEn),
  .memWrAddr(memWrAddr),
  .memWrData(memWrData),
  .memCommit(memCommit),
  .bufEmpty (bufEmpty),
  .bufFull  (bufFull),
  .occupancy(occupancy),
  .validVec (validVec)
);

// File: tb/store_drain_queue_tb.sv
`timescale 1ns/1ps
module store_drain_queue_tb_top;

  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int DEPTH   = 4;
  localparam int MEM_LAT = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stValid = 1'b0;
  logic [ADDR_W-1:0] stAddr = '0;
  logic [DATA_W-1:0] stData = '0;
  logic rdMissReq = 1'b0;
  logic stStall, rdStall, memWrEn, memCommit, bufEmpty, bufFull;
  logic [ADDR_W-1:0] memWrAddr;
  logic [DATA_W-1:0] memWrData;

  int total = 0;
  int bad = 0;
  int accepted = 0;
  int committed = 0;
  logic [63:0] expQ[$];
  logic [DATA_W-1:0] memModel [int];

  always #2.5 clk = ~clk;

  store_drain_queue #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .MEM_LAT(MEM_LAT)
  ) dut_i (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stAddr(stAddr), .stData(stData),
    .stStall(stStall), .rdMissReq(rdMissReq), .rdStall(rdStall),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memCommit(memCommit), .bufEmpty(bufEmpty), .bufFull(bufFull)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doStore(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stData = d;
    #1;
    while (stStall) begin
      @(negedge clk);
      #1;
    end
    expQ.push_back({a, d});
    accepted++;
    @(posedge clk);
    #1;
    stValid = 1'b0;
  endtask

  task automatic waitEmpty();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      #1;
      if (bufEmpty && !memWrEn) break;
    end
  endtask

  // monitor: scoreboard, write length, address stability, drain gap
  initial begin
    int runLen = 0;
    bit gapPending = 0;
    logic [ADDR_W-1:0] prevAddr = '0;
    logic [DATA_W-1:0] prevData = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rstN) begin
        if (gapPending && !bufEmpty)
          check(memWrEn, "R9 next write starts at once", memWrEn, 1);
        gapPending = 0;
        if (memWrEn) begin
          runLen++;
          if (runLen > 1)
            check(memWrAddr == prevAddr && memWrData == prevData,
                  "R4 write address/data stable", memWrAddr, prevAddr);
          prevAddr = memWrAddr;
          prevData = memWrData;
        end
        if (memCommit) begin
          check(runLen == MEM_LAT, "R4 write length", runLen, MEM_LAT);
          runLen = 0;
          gapPending = 1;
          committed++;
          if (expQ.size() == 0) begin
            check(0, "R2 unexpected memory write", memWrAddr, 0);
          end else begin
            logic [63:0] e;
            e = expQ.pop_front();
            check({memWrAddr, memWrData} == e, "R3 write order/content",
                  {memWrAddr, memWrData}, e);
          end
          memModel[int'(memWrAddr)] = memWrData;
        end
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(bufEmpty == 1'b1, "R1 empty after reset", bufEmpty, 1);
    check(bufFull == 1'b0, "R1 not full after reset", bufFull, 0);
    check(memWrEn == 1'b0, "R1 no write after reset", memWrEn, 0);
    check(stStall == 1'b0 && rdStall == 1'b0, "R1 no stall after reset",
          {stStall, rdStall}, 0);

    // single store
    doStore(32'h100, 32'hA1);
    check(bufEmpty == 1'b0, "R8 not empty after one store", bufEmpty, 0);
    waitEmpty();
    check(bufEmpty == 1'b1, "R8 empty after drain", bufEmpty, 1);

    // fill to full, then one more store
    doStore(32'h200, 32'hB0);
    doStore(32'h204, 32'hB1);
    doStore(32'h208, 32'hB2);
    doStore(32'h20C, 32'hB3);
    @(negedge clk);
    stValid = 1'b1; stAddr = 32'h210; stData = 32'hB4;
    #1;
    check(bufFull == 1'b1, "R8 full with DEPTH stores", bufFull, 1);
    check(stStall == 1'b1, "R5 store held while full", stStall, 1);
    begin
      int waitCnt = 0;
      while (stStall && waitCnt < 50) begin
        @(negedge clk);
        #1;
        waitCnt++;
      end
    end
    check(memCommit == 1'b1, "R6 release coincides with commit", memCommit, 1);
    check(bufFull == 1'b1, "R6 full at release", bufFull, 1);
    expQ.push_back({32'h210, 32'hB4});
    accepted++;
    @(posedge clk);
    #1;
    stValid = 1'b0;
    @(negedge clk);
    #1;
    check(bufFull == 1'b1, "R6 still full after swap", bufFull, 1);
    doStore(32'h214, 32'hB5);
    waitEmpty();

    // read miss behind pending stores, with an overwrite
    doStore(32'h300, 32'hC0);
    doStore(32'h100, 32'hA2);
    doStore(32'h304, 32'hC1);
    @(negedge clk);
    rdMissReq = 1'b1;
    for (int i = 0; i < 100; i++) begin
      #1;
      check(rdStall == !bufEmpty, "R7 read stall tracks empty", rdStall, !bufEmpty);
      if (!rdStall) break;
      @(negedge clk);
    end
    check(rdStall == 1'b0, "R7 read released", rdStall, 0);
    check(expQ.size() == 0, "R7 all stores done before read", expQ.size(), 0);
    check(memWrEn == 1'b0, "R7 memory idle at read", memWrEn, 0);
    @(negedge clk);
    rdMissReq = 1'b0;

    // read miss on an empty queue passes at once
    #1;
    rdMissReq = 1'b1;
    #0.5;
    check(rdStall == 1'b0, "R7 no stall when empty", rdStall, 0);
    rdMissReq = 1'b0;

    repeat (3) @(negedge clk);
    #1;
    check(committed == accepted, "R2 one write per store", committed, accepted);
    check(memModel.exists(32'h100) && memModel[32'h100] == 32'hA2,
          "R3 latest data wins", memModel.exists(32'h100) ? memModel[32'h100] : 0, 32'hA2);
    check(memModel.exists(32'h214) && memModel[32'h214] == 32'hB5,
          "R2 data written", memModel.exists(32'h214) ? memModel[32'h214] : 0, 32'hB5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule